// File: doc/BRIEF.md
# Fusion-Aware Decode Slot Allocator

This block sits between a queue of predecoded instructions and a set of decoders. Every cycle it looks at a window of the oldest queue entries and decides how many of them go to decode that cycle. Each entry carries a byte length, a micro-op count, a flag saying it can start a fusion, and a flag saying it is a conditional jump. One decoder can take a multi-micro-op instruction, but only in the first position of the cycle. The others each take one single-micro-op instruction. An arithmetic or logical instruction that is directly followed by a jump is merged into one compute-and-jump micro-op.

The allocator emits up to four micro-op descriptors into a decoded-op queue, one cycle after the decision. It tells the instruction queue, in the same cycle, how many entries to pop and how many bytes those entries span. Two limits shape the result:

- Once the second fusion of a cycle is done, nothing more is decoded in that cycle.
- A fusion-capable instruction that would land in the last micro-op position waits for the next cycle, so that its successor can be examined there.

When the decoded-op queue has no room, allocation stalls and no entry is lost. Three counters track the decode throughput.

Top module: `fdec_alloc`

## Requirements
- R1: After reset, all four descriptor valid bits are 0, all three counters are 0, and `take` is 0 while no window entry is valid.
- R2: Entries are allocated strictly in window order, from entry 0 upward. Allocation stops at the first entry whose valid bit is 0. `take` gives the number of entries consumed, from 0 to 5. The descriptors of a decision appear on the next clock edge, packed into positions 0 upward, and the index field of each descriptor names the window entry it came from.
- R3: A single-micro-op entry that does not fuse produces one descriptor with fused=0 and seq=0. This includes a jump whose predecessor did not fuse, and a fusion-capable entry whose successor is not a valid jump.
- R4: The micro-op count of an entry is its 2-bit count field plus 1. An entry with a count above 1 is allocated only at micro-op position 0, where it emits one descriptor per micro-op with seq 0, 1, 2 and so on. At any later position it halts allocation for the cycle. Its fusion flag has no effect.
- R5: No more than four micro-ops are emitted per cycle. Once position 3 is filled, every later entry waits.
- R6: A fusion-capable entry with a count field of 0 whose successor entry is valid and flagged as a jump is fused with it. The pair produces one descriptor with fused=1 and the index of the first entry, and both entries are consumed. Byte lengths have no effect on fusion, so a pair that straddles a 16-byte boundary still fuses.
- R7: At most two fusions occur per cycle. After the second one, no further entry is allocated in that cycle, even if positions are free.
- R8: A fusion-capable entry with a count field of 0 that would occupy micro-op position 3 is not allocated. It and every later entry wait for the next cycle.
- R9: `take_bytes` equals the sum of the length fields of the consumed entries.
- R10: While `dq_room` is 0, `take` and `take_bytes` are 0, and no descriptor is valid on the next cycle.
- R11: The counters are updated one cycle after the descriptors appear:
  - `cnt_active` counts cycles with at least one valid descriptor.
  - `cnt_uops` counts valid descriptors.
  - `cnt_fused` counts valid fused descriptors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 5 | Window entry valid, bit i for entry i |
| in_arith | input | 5 | Entry can start a fusion |
| in_jump | input | 5 | Entry is a conditional jump |
| in_um1 | input | 10 | Micro-op count minus 1, 2 bits per entry |
| in_len | input | 20 | Byte length, 4 bits per entry |
| dq_room | input | 1 | Decoded-op queue can take four micro-ops |
| take | output | 3 | Entries consumed this cycle |
| take_bytes | output | 7 | Bytes consumed this cycle |
| dq_vld | output | 4 | Descriptor valid per position |
| dq_fused | output | 4 | Descriptor is a fused compute-and-jump |
| dq_idx | output | 12 | Source window index, 3 bits per position |
| dq_seq | output | 8 | Micro-op sequence within its entry, 2 bits per position |
| cnt_active | output | 32 | Cycles with micro-op delivery |
| cnt_uops | output | 32 | Micro-ops delivered |
| cnt_fused | output | 32 | Fusions performed |

## Verification
The following are checked on every cycle:
- descriptors are packed from position 0 upward;
- no more than two descriptors per cycle are fused;
- position 3 never carries a fused descriptor;
- a stall or an empty decision leaves the next cycle without descriptors;
- the micro-op counter never moves backwards.

Some results depend on the content of the window and can only be shown by the bench's sweep over every mix of entry kinds:
- the exact number of entries consumed;
- the halt after the second fusion;
- the deferral of a fusion candidate from the last position;
- the position-0-only rule for multi-micro-op entries.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
    localparam int WIN     = 5;
    localparam int UOPS    = 4;
    localparam int MAXF    = 2;
    localparam int LEN_W   = 4;
    localparam int UM_W    = $clog2(UOPS);
    localparam int IDX_W   = $clog2(WIN);
    localparam int SEQ_W   = $clog2(UOPS);
    localparam int TAKE_W  = $clog2(WIN + 1);
    localparam int POS_W   = $clog2(UOPS + 1);
    localparam int SLOT_W  = $clog2(UOPS);
    localparam int FUS_W   = $clog2(MAXF + 1);
    localparam int BYTES_W = $clog2(WIN * ((1 << LEN_W) - 1) + 1);
    localparam int CNTU_W  = $clog2(UOPS + 1);

    typedef struct packed {
        logic             vld;
        logic             fused;
        logic [IDX_W-1:0] idx;
        logic [SEQ_W-1:0] seq;
    } desc_t;
endpackage

// File: rtl/fdec_walk.sv
module fdec_walk
    import fdec_pkg::*;
(
    input  logic [WIN-1:0]       vld,
    input  logic [WIN-1:0]       arith,
    input  logic [WIN-1:0]       jump,
    input  logic [WIN*UM_W-1:0]  um1,
    input  logic [WIN*LEN_W-1:0] len,
    output logic [TAKE_W-1:0]    take,
    output logic [BYTES_W-1:0]   bytes,
    output desc_t [UOPS-1:0]     slot
);
    logic [WIN-1:0]   nxt_j;
    logic [LEN_W-1:0] nxt_l [WIN];

    for (genvar g = 0; g < WIN; g++) begin : g_look
        if (g < WIN - 1) begin : g_has
            assign nxt_j[g] = vld[g+1] & jump[g+1];
            assign nxt_l[g] = len[(g+1)*LEN_W +: LEN_W];
        end else begin : g_end
            assign nxt_j[g] = 1'b0;
            assign nxt_l[g] = '0;
        end
    end

    always_comb begin
        logic [POS_W-1:0] pos;
        logic [FUS_W-1:0] nf;
        logic             halt;
        logic             skip;
        logic [UM_W-1:0]  u;
        logic [LEN_W-1:0] l;
        pos   = '0;
        nf    = '0;
        halt  = 1'b0;
        skip  = 1'b0;
        take  = '0;
        bytes = '0;
        slot  = '0;
        for (int i = 0; i < WIN; i++) begin
            u = um1[i*UM_W +: UM_W];
            l = len[i*LEN_W +: LEN_W];
            if (skip) begin
                skip = 1'b0;
            end else if (!halt) begin
                if (!vld[i] || nf == FUS_W'(MAXF) || pos == POS_W'(UOPS)) begin
                    halt = 1'b1;
                end else if (u != '0) begin
                    if (pos != '0) begin
                        halt = 1'b1;
                    end else begin
                        for (int k = 0; k < UOPS; k++) begin
                            if (k <= int'(u)) begin
                                slot[k].vld   = 1'b1;
                                slot[k].fused = 1'b0;
                                slot[k].idx   = IDX_W'(i);
                                slot[k].seq   = SEQ_W'(k);
                            end
                        end
                        pos   = POS_W'(u) + POS_W'(1);
                        take  = TAKE_W'(i + 1);
                        bytes = bytes + BYTES_W'(l);
                    end
                end else if (arith[i] && pos == POS_W'(UOPS - 1)) begin
                    halt = 1'b1;
                end else begin
                    slot[pos[SLOT_W-1:0]].vld = 1'b1;
                    slot[pos[SLOT_W-1:0]].idx = IDX_W'(i);
                    slot[pos[SLOT_W-1:0]].seq = '0;
                    bytes = bytes + BYTES_W'(l);
                    if (arith[i] && nxt_j[i]) begin
                        slot[pos[SLOT_W-1:0]].fused = 1'b1;
                        bytes = bytes + BYTES_W'(nxt_l[i]);
                        nf    = nf + FUS_W'(1);
                        take  = TAKE_W'(i + 2);
                        skip  = 1'b1;
                    end else begin
                        slot[pos[SLOT_W-1:0]].fused = 1'b0;
                        take = TAKE_W'(i + 1);
                    end
                    pos = pos + POS_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/fdec_stats.sv
module fdec_stats
    import fdec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  desc_t [UOPS-1:0] dq,
    output logic [CNT_W-1:0] cnt_active,
    output logic [CNT_W-1:0] cnt_uops,
    output logic [CNT_W-1:0] cnt_fused
);
    typedef struct packed {
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] uops;
        logic [CNT_W-1:0] fused;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        logic [CNTU_W-1:0] nu;
        logic [CNTU_W-1:0] nfz;
        nu  = '0;
        nfz = '0;
        for (int k = 0; k < UOPS; k++) begin
            nu  = nu + CNTU_W'(dq[k].vld);
            nfz = nfz + CNTU_W'(dq[k].vld & dq[k].fused);
        end
        st_d        = st_q;
        st_d.uops   = st_q.uops + CNT_W'(nu);
        st_d.fused  = st_q.fused + CNT_W'(nfz);
        if (nu != '0) begin
            st_d.active = st_q.active + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_active = st_q.active;
    assign cnt_uops   = st_q.uops;
    assign cnt_fused  = st_q.fused;
endmodule

// File: rtl/fdec_alloc.sv
module fdec_alloc
    import fdec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WIN-1:0]          in_vld,
    input  logic [WIN-1:0]          in_arith,
    input  logic [WIN-1:0]          in_jump,
    input  logic [WIN*UM_W-1:0]     in_um1,
    input  logic [WIN*LEN_W-1:0]    in_len,
    input  logic                    dq_room,
    output logic [TAKE_W-1:0]       take,
    output logic [BYTES_W-1:0]      take_bytes,
    output logic [UOPS-1:0]         dq_vld,
    output logic [UOPS-1:0]         dq_fused,
    output logic [UOPS*IDX_W-1:0]   dq_idx,
    output logic [UOPS*SEQ_W-1:0]   dq_seq,
    output logic [CNT_W-1:0]        cnt_active,
    output logic [CNT_W-1:0]        cnt_uops,
    output logic [CNT_W-1:0]        cnt_fused
);
    typedef struct packed {
        desc_t [UOPS-1:0] dq;
    } st_t;

    st_t                 st_d, st_q;
    logic [TAKE_W-1:0]   w_take;
    logic [BYTES_W-1:0]  w_bytes;
    desc_t [UOPS-1:0]    w_slot;

    fdec_walk i_walk (
        .vld   (in_vld),
        .arith (in_arith),
        .jump  (in_jump),
        .um1   (in_um1),
        .len   (in_len),
        .take  (w_take),
        .bytes (w_bytes),
        .slot  (w_slot)
    );

    always_comb begin
        st_d    = st_q;
        st_d.dq = dq_room ? w_slot : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take       = dq_room ? w_take : '0;
    assign take_bytes = dq_room ? w_bytes : '0;

    for (genvar g = 0; g < UOPS; g++) begin : g_out
        assign dq_vld[g]                   = st_q.dq[g].vld;
        assign dq_fused[g]                 = st_q.dq[g].fused;
        assign dq_idx[g*IDX_W +: IDX_W]    = st_q.dq[g].idx;
        assign dq_seq[g*SEQ_W +: SEQ_W]    = st_q.dq[g].seq;
    end

    fdec_stats #(.CNT_W(CNT_W)) i_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .dq         (st_q.dq),
        .cnt_active (cnt_active),
        .cnt_uops   (cnt_uops),
        .cnt_fused  (cnt_fused)
    );
endmodule

// File: rtl/fdec_chk.sv
module fdec_chk
    import fdec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dq_room,
    input logic [TAKE_W-1:0] take,
    input logic [UOPS-1:0]   dq_vld,
    input logic [UOPS-1:0]   dq_fused,
    input logic [CNT_W-1:0]  cnt_uops
);
    a_r10_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_room |=> dq_vld == '0);

    a_r2_take_emits: assert property (@(posedge clk) disable iff (!rst_n)
        take != '0 |=> dq_vld[0]);

    a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        take == '0 |=> dq_vld == '0);

    a_r2_packed_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((dq_vld + UOPS'(1)) & dq_vld) == '0);

    a_r7_two_fusions: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dq_fused) <= MAXF);

    a_r6_fused_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_fused & ~dq_vld) == '0);

    a_r8_no_last_fuse: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_fused[UOPS-1]);

    a_r11_uops_mono: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_uops >= $past(cnt_uops));
endmodule

bind fdec_alloc fdec_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dq_room  (dq_room),
    .take     (take),
    .dq_vld   (dq_vld),
    .dq_fused (dq_fused),
    .cnt_uops (cnt_uops)
);

// File: tb/test_fdec_alloc.sv
`timescale 1ns/1ps
module test_fdec_alloc;
    import fdec_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [WIN-1:0]        in_vld = '0;
    logic [WIN-1:0]        in_arith = '0;
    logic [WIN-1:0]        in_jump = '0;
    logic [WIN*UM_W-1:0]   in_um1 = '0;
    logic [WIN*LEN_W-1:0]  in_len = '0;
    logic                  dq_room = 1'b1;
    logic [TAKE_W-1:0]     take;
    logic [BYTES_W-1:0]    take_bytes;
    logic [UOPS-1:0]       dq_vld;
    logic [UOPS-1:0]       dq_fused;
    logic [UOPS*IDX_W-1:0] dq_idx;
    logic [UOPS*SEQ_W-1:0] dq_seq;
    logic [31:0]           cnt_active, cnt_uops, cnt_fused;

    fdec_alloc i_fdec_alloc (.*);

    always #10 clk = ~clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [UOPS-1:0]       e_vld, e_fus;
    logic [UOPS*IDX_W-1:0] e_idx;
    logic [UOPS*SEQ_W-1:0] e_seq;
    int                    e_take, e_bytes, e_nu, e_nf;
    string                 e_tag;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic ref_model();
        int s, f, p;
        bit stop, sing, mult, fus;
        s = 0; f = 0; p = 0; stop = 0;
        sing = 0; mult = 0; fus = 0;
        e_vld = '0; e_fus = '0; e_idx = '0; e_seq = '0;
        e_bytes = 0; e_tag = "R2";
        while (!stop) begin
            if (p >= WIN || !in_vld[p]) begin
                stop = 1;
            end else if (f == MAXF) begin
                stop = 1; e_tag = "R7";
            end else if (s == UOPS) begin
                stop = 1; e_tag = "R5";
            end else if (in_um1[p*UM_W +: UM_W] != 0) begin
                if (s != 0) begin
                    stop = 1; e_tag = "R4";
                end else begin
                    for (int k = 0; k <= int'(in_um1[p*UM_W +: UM_W]); k++) begin
                        e_vld[k] = 1'b1;
                        e_idx[k*IDX_W +: IDX_W] = IDX_W'(p);
                        e_seq[k*SEQ_W +: SEQ_W] = SEQ_W'(k);
                    end
                    s = int'(in_um1[p*UM_W +: UM_W]) + 1;
                    e_bytes += int'(in_len[p*LEN_W +: LEN_W]);
                    mult = 1;
                    p++;
                end
            end else if (in_arith[p] && s == UOPS - 1) begin
                stop = 1; e_tag = "R8";
            end else begin
                e_vld[s] = 1'b1;
                e_idx[s*IDX_W +: IDX_W] = IDX_W'(p);
                e_bytes += int'(in_len[p*LEN_W +: LEN_W]);
                if (in_arith[p] && p + 1 < WIN && in_vld[p+1] && in_jump[p+1]) begin
                    e_fus[s] = 1'b1;
                    e_bytes += int'(in_len[(p+1)*LEN_W +: LEN_W]);
                    f++; fus = 1;
                    p += 2;
                end else begin
                    sing = 1;
                    p++;
                end
                s++;
            end
        end
        if (e_tag == "R2") begin
            if (fus) e_tag = "R6";
            else if (mult) e_tag = "R4";
            else if (sing) e_tag = "R3";
        end
        e_take = p;
        e_nu = s;
        e_nf = f;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int  x_act, x_nu, x_nf;
        bit  have_prev;
        bit  p_room;
        logic [UOPS-1:0]       p_vld, p_fus;
        logic [UOPS*IDX_W-1:0] p_idx;
        logic [UOPS*SEQ_W-1:0] p_seq;
        string                 p_tag;
        x_act = 0; x_nu = 0; x_nf = 0;
        have_prev = 0;
        p_room = 1; p_vld = '0; p_fus = '0; p_idx = '0; p_seq = '0; p_tag = "";

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(dq_vld == '0, "R1", "dq_vld", dq_vld, 0);
        check(cnt_active == 0 && cnt_uops == 0 && cnt_fused == 0, "R1", "counters",
              cnt_uops, 0);
        check(take == 0, "R1", "take", take, 0);

        for (int v = 0; v < 7776; v++) begin
            int c;
            c = v;
            if (have_prev) begin
                if (!p_room) begin
                    check(dq_vld == '0, "R10", "dq_vld stalled", dq_vld, 0);
                end else begin
                    check(dq_vld == p_vld && dq_fused == p_fus, p_tag, "vld/fused",
                          {dq_vld, dq_fused}, {p_vld, p_fus});
                    check((dq_idx & idx_mask(p_vld)) == p_idx &&
                          (dq_seq & seq_mask(p_vld)) == p_seq, p_tag, "idx/seq",
                          {dq_idx, dq_seq}, {p_idx, p_seq});
                end
            end
            for (int e = 0; e < WIN; e++) begin
                int t;
                t = c % 6;
                c = c / 6;
                in_vld[e]   = (t != 0);
                in_arith[e] = (t == 2);
                in_jump[e]  = (t == 3);
                in_um1[e*UM_W +: UM_W] = (t == 4) ? UM_W'(1) : (t == 5) ? UM_W'(3) : '0;
                in_len[e*LEN_W +: LEN_W] = LEN_W'((e * 3 + t * 5 + v) % 16);
            end
            dq_room = (v % 13 != 7);
            #1;
            ref_model();
            if (!dq_room) begin
                check(take == 0 && take_bytes == 0, "R10", "take stalled",
                      {take, take_bytes}, 0);
            end else begin
                check(int'(take) == e_take, e_tag, "take", take, e_take);
                check(int'(take_bytes) == e_bytes, "R9", "take_bytes", take_bytes, e_bytes);
                if (e_nu != 0) x_act++;
                x_nu += e_nu;
                x_nf += e_nf;
            end
            have_prev = 1;
            p_room = dq_room;
            p_vld = e_vld; p_fus = e_fus; p_idx = e_idx; p_seq = e_seq; p_tag = e_tag;
            @(negedge clk);
        end
        if (p_room) begin
            check(dq_vld == p_vld && dq_fused == p_fus, p_tag, "vld/fused last",
                  {dq_vld, dq_fused}, {p_vld, p_fus});
        end
        in_vld = '0;
        dq_room = 1'b1;
        repeat (2) @(negedge clk);
        // R11: throughput counters
        check(int'(cnt_active) == x_act, "R11", "cnt_active", cnt_active, x_act);
        check(int'(cnt_uops) == x_nu, "R11", "cnt_uops", cnt_uops, x_nu);
        check(int'(cnt_fused) == x_nf, "R11", "cnt_fused", cnt_fused, x_nf);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    function automatic logic [UOPS*IDX_W-1:0] idx_mask(input logic [UOPS-1:0] m);
        idx_mask = '0;
        for (int k = 0; k < UOPS; k++)
            if (m[k]) idx_mask[k*IDX_W +: IDX_W] = '1;
    endfunction

    function automatic logic [UOPS*SEQ_W-1:0] seq_mask(input logic [UOPS-1:0] m);
        seq_mask = '0;
        for (int k = 0; k < UOPS; k++)
            if (m[k]) seq_mask[k*SEQ_W +: SEQ_W] = '1;
    endfunction
endmodule